// File: doc/BRIEF.md
# Three-Phase Commutation Signal Generator

This block turns an absolute mechanical angle into three square waves, U, V and W, of the kind a brushless motor drive expects from Hall sensors. The three waves are spaced a third of an electrical period apart. Each is high for half of that period. A pole-select input makes the six-step pattern run once per mechanical revolution (2-pole) or twice per revolution (4-pole).

An 8-bit zero-offset code places the rising edge of U at one of 192 evenly spaced positions over a revolution. Codes from 192 to 255 do not add new positions. They fold back onto earlier positions by a fixed rule.

The angle arrives as samples qualified by a valid strobe. The outputs are registered, so they move only on the clock edge that takes a valid sample and hold between samples.

Top module: `comm_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first valid sample, (U,V,W) = (1,0,1), which is the sector-0 state.
- R2: The angle is quantised to a grid position p = floor(angle * 192 / 2^ANG_W), giving p in the range 0 to 191.
- R3: A zero code c below 192 selects zero position c. A code of 192 to 255 selects position c - 80, so code 0xC0 acts as 0x70 and code 0xFF acts as 175.
- R4: The relative position is d = (p - zero position) mod 192. U therefore rises where p equals the zero position.
- R5: With pole_sel = 0, the sector is d / 32, in the range 0 to 5, and the pattern repeats once per revolution.
- R6: With pole_sel = 1, the sector is (d mod 96) / 16, and the pattern repeats twice per revolution.
- R7: Sectors 0 to 5 map to (U,V,W) = 101, 100, 110, 010, 011, 001. U is high in sectors 0 to 2, V in sectors 2 to 4 and W in sectors 4, 5 and 0.
- R8: The outputs take the value for the sampled angle on the clock edge where angle_valid is high. With angle_valid low they hold, whatever the angle, pole or code inputs do.
- R9: (U,V,W) is never 000 and never 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| angle_valid | input | 1 | Qualifies the angle sample on this edge |
| angle | input | ANG_W (12) | Absolute mechanical angle, full scale = one revolution |
| pole_sel | input | 1 | 0 = 2-pole, 1 = 4-pole repetition |
| zero_code | input | ZERO_W (8) | Commutation zero position code |
| u_out | output | 1 | Phase U commutation signal |
| v_out | output | 1 | Phase V commutation signal |
| w_out | output | 1 | Phase W commutation signal |

## Verification
A new angle sample can arrive in the same cycle that the pole setting or the zero code changes. The new configuration and the new angle must then take effect together, with no output that mixes old and new. The bench provokes this by changing pole_sel and zero_code, including a folded code, on the same edge as a valid sample. It compares the registered outputs one cycle later against a model built only from the new inputs. A companion case changes the configuration while angle_valid is low and checks that the outputs do not move.

// File: rtl/comm_pkg.sv
package comm_pkg;

   // Number of electrical sectors in one commutation period
   localparam int unsigned NUM_SECTORS = 6;

   typedef logic [2:0] sector_t;

   typedef struct packed {
      logic u;
      logic v;
      logic w;
   } phase_t;

   // Six-step pattern: U rises entering sector 0, V entering 2, W entering 4
   function automatic phase_t sector_to_phase(input sector_t s);
      phase_t p;
      unique case (s)
         3'd0:    p = '{u: 1'b1, v: 1'b0, w: 1'b1};
         3'd1:    p = '{u: 1'b1, v: 1'b0, w: 1'b0};
         3'd2:    p = '{u: 1'b1, v: 1'b1, w: 1'b0};
         3'd3:    p = '{u: 1'b0, v: 1'b1, w: 1'b0};
         3'd4:    p = '{u: 1'b0, v: 1'b1, w: 1'b1};
         3'd5:    p = '{u: 1'b0, v: 1'b0, w: 1'b1};
         default: p = '{u: 1'b1, v: 1'b0, w: 1'b1};
      endcase
      return p;
   endfunction

endpackage

// File: rtl/comm_zero_fold.sv
module comm_zero_fold #(
   parameter int unsigned ZERO_W    = 8,
   parameter int unsigned POSITIONS = 192,
   parameter int unsigned FOLD_SUB  = 80,
   parameter int unsigned POS_W     = $clog2(POSITIONS)
) (
   input  logic [ZERO_W-1:0] zero_code,
   output logic [POS_W-1:0]  zero_pos
);
   localparam int unsigned CODE_MAX = (1 << ZERO_W) - 1;

   if (FOLD_SUB > POSITIONS || (CODE_MAX - FOLD_SUB) >= POSITIONS) begin : g_bad_fold
      $error("comm_zero_fold: folded codes would leave the position range");
   end

   logic [ZERO_W-1:0] folded;

   always_comb begin
      if (zero_code >= ZERO_W'(POSITIONS)) begin
         folded = zero_code - ZERO_W'(FOLD_SUB);
      end else begin
         folded = zero_code;
      end
      zero_pos = POS_W'(folded);
   end

   // R3: the folded position always lands inside the grid
   always_comb begin
      assert_pos_in_range_R3: assert (zero_pos < POS_W'(POSITIONS));
   end

endmodule

// File: rtl/comm_sector.sv
module comm_sector
   import comm_pkg::*;
#(
   parameter int unsigned ANG_W     = 12,
   parameter int unsigned POSITIONS = 192,
   parameter int unsigned POS_W     = $clog2(POSITIONS)
) (
   input  logic [ANG_W-1:0] angle,
   input  logic [POS_W-1:0] zero_pos,
   input  logic             pole_sel,
   output sector_t          sector
);
   localparam int unsigned PROD_W = ANG_W + POS_W;
   localparam int unsigned HALF   = POSITIONS / 2;
   localparam int unsigned STEP2  = POSITIONS / NUM_SECTORS;
   localparam int unsigned STEP4  = STEP2 / 2;
   localparam bit          POW2   = (STEP2 & (STEP2 - 1)) == 0;

   if (POSITIONS % (2 * NUM_SECTORS) != 0) begin : g_bad_grid
      $error("comm_sector: POSITIONS must be a multiple of 12");
   end

   logic [PROD_W-1:0] prod;
   logic [POS_W-1:0]  grid_pos;
   logic [POS_W:0]    sum;
   logic [POS_W-1:0]  rel;
   logic [POS_W-1:0]  elec;
   logic [POS_W-1:0]  sec2;
   logic [POS_W-1:0]  sec4;

   always_comb begin
      prod     = PROD_W'(angle) * PROD_W'(POSITIONS);
      grid_pos = prod[PROD_W-1:ANG_W];
      sum      = {1'b0, grid_pos} + (POS_W+1)'(POSITIONS) - {1'b0, zero_pos};
      if (sum >= (POS_W+1)'(POSITIONS)) begin
         rel = POS_W'(sum - (POS_W+1)'(POSITIONS));
      end else begin
         rel = POS_W'(sum);
      end
      if (pole_sel && rel >= POS_W'(HALF)) begin
         elec = rel - POS_W'(HALF);
      end else begin
         elec = rel;
      end
   end

   if (POW2) begin : g_shift_div
      localparam int unsigned SH2 = $clog2(STEP2);
      assign sec2 = elec >> SH2;
      assign sec4 = elec >> (SH2 - 1);
   end else begin : g_const_div
      assign sec2 = elec / POS_W'(STEP2);
      assign sec4 = elec / POS_W'(STEP4);
   end

   assign sector = pole_sel ? sector_t'(sec4) : sector_t'(sec2);

endmodule

// File: rtl/comm_wave_reg.sv
module comm_wave_reg
   import comm_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    load,
   input  sector_t sector,
   output phase_t  phase
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase <= sector_to_phase(3'd0);
      end else if (load) begin
         phase <= sector_to_phase(sector);
      end
   end

   // R5/R6: a loaded sector is one of the six steps
   assert_sector_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (sector < sector_t'(NUM_SECTORS)));

   // R8: no load, no change
   assert_hold_without_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(phase));

   // R9: never all low or all high
   assert_no_flat_state_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(phase) == 1) || ($countones(phase) == 2));

endmodule

// File: rtl/comm_gen.sv
module comm_gen
   import comm_pkg::*;
#(
   parameter int unsigned ANG_W     = 12,
   parameter int unsigned ZERO_W    = 8,
   parameter int unsigned POSITIONS = 192,
   parameter int unsigned FOLD_SUB  = 80
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              angle_valid,
   input  logic [ANG_W-1:0]  angle,
   input  logic              pole_sel,
   input  logic [ZERO_W-1:0] zero_code,
   output logic              u_out,
   output logic              v_out,
   output logic              w_out
);
   localparam int unsigned POS_W = $clog2(POSITIONS);

   if (ANG_W < POS_W) begin : g_bad_ang
      $error("comm_gen: angle narrower than the position grid");
   end

   logic [POS_W-1:0] zero_pos;
   sector_t          sector;
   phase_t           phase;

   comm_zero_fold #(
      .ZERO_W    (ZERO_W),
      .POSITIONS (POSITIONS),
      .FOLD_SUB  (FOLD_SUB),
      .POS_W     (POS_W)
   ) u_fold (
      .zero_code (zero_code),
      .zero_pos  (zero_pos)
   );

   comm_sector #(
      .ANG_W     (ANG_W),
      .POSITIONS (POSITIONS),
      .POS_W     (POS_W)
   ) u_sector (
      .angle     (angle),
      .zero_pos  (zero_pos),
      .pole_sel  (pole_sel),
      .sector    (sector)
   );

   comm_wave_reg u_wave (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (angle_valid),
      .sector (sector),
      .phase  (phase)
   );

   assign u_out = phase.u;
   assign v_out = phase.v;
   assign w_out = phase.w;

   // R1: the first edge after reset leaves the sector-0 state unless a sample loads
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!rst_n) && !angle_valid) |=> ({u_out, v_out, w_out} == 3'b101));

endmodule

// File: tb/tb_comm_gen.sv
module tb_comm_gen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        angle_valid = 1'b0;
   logic [11:0] angle = '0;
   logic        pole_sel = 1'b0;
   logic [7:0]  zero_code = '0;
   logic        u_out, v_out, w_out;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   comm_gen dut (
      .clk(clk), .rst_n(rst_n), .angle_valid(angle_valid), .angle(angle),
      .pole_sel(pole_sel), .zero_code(zero_code),
      .u_out(u_out), .v_out(v_out), .w_out(w_out)
   );

   function automatic logic [2:0] model(input int ang, input bit pole, input int code);
      int zp, p, d, s;
      zp = (code >= 192) ? code - 80 : code;       // R3
      p  = (ang * 192) >> 12;                       // R2
      d  = (p - zp + 192) % 192;                    // R4
      if (pole) s = (d % 96) / 16;                  // R6
      else      s = d / 32;                         // R5
      case (s)                                      // R7
         0: return 3'b101;
         1: return 3'b100;
         2: return 3'b110;
         3: return 3'b010;
         4: return 3'b011;
         default: return 3'b001;
      endcase
   endfunction

   task automatic check(input logic [2:0] exp, input string req);
      logic [2:0] act;
      act = {u_out, v_out, w_out};
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: uvw=%b expected %b", req, act, exp);
      end
      if (act == 3'b000 || act == 3'b111) begin
         fails++;
         $display("FAIL R9: uvw=%b expected neither 000 nor 111", act);
      end
   endtask

   // One valid sample; outputs load on the next rising edge, sampled at the negedge after
   task automatic sample(input int ang, input bit pole, input int code, input string req);
      @(negedge clk);
      angle = 12'(ang); pole_sel = pole; zero_code = 8'(code); angle_valid = 1'b1;
      @(negedge clk);
      angle_valid = 1'b0;
      check(model(ang, pole, code), req);
   endtask

   task automatic t_reset;
      @(negedge clk);
      check(3'b101, "R1 in reset");
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      check(3'b101, "R1 after release");
   endtask

   task automatic t_two_pole;
      for (int k = 0; k < 12; k++) sample(k * 341 + 5, 1'b0, 0, "R5 2-pole sweep");
      sample(4095, 1'b0, 0, "R2 full-scale angle");
      sample(21, 1'b0, 0, "R2 grid boundary");
      sample(22, 1'b0, 0, "R2 grid boundary+1");
   endtask

   task automatic t_four_pole;
      for (int k = 0; k < 12; k++) sample(k * 341 + 7, 1'b1, 0, "R6 4-pole sweep");
      sample(2048, 1'b1, 0, "R6 second repeat start");
   endtask

   task automatic t_offset;
      sample(2048, 1'b0, 96, "R4 U rises at zero position");
      sample(2047, 1'b0, 96, "R4 just before zero position");
      sample(100, 1'b0, 191, "R4 wrap across zero");
      sample(1000, 1'b1, 50, "R4 offset 4-pole");
   endtask

   task automatic t_fold;
      sample(1195, 1'b0, 8'hC0, "R3 code C0 folds to 112");
      sample(1195, 1'b0, 8'h70, "R3 code 70 reference");
      sample(2900, 1'b0, 8'hFF, "R3 code FF folds to 175");
      sample(3000, 1'b1, 8'hD5, "R3 folded code 4-pole");
   endtask

   task automatic t_table;
      for (int s = 0; s < 6; s++) sample(s * 683 + 10, 1'b0, 0, "R7 sector pattern");
   endtask

   task automatic t_hold;
      logic [2:0] held;
      sample(1500, 1'b0, 0, "R8 load before hold");
      held = {u_out, v_out, w_out};
      @(negedge clk);
      angle = 12'd3500; pole_sel = 1'b1; zero_code = 8'd77;
      repeat (3) @(negedge clk);
      check(held, "R8 hold with valid low");
   endtask

   task automatic t_same_cycle;
      sample(500, 1'b0, 10, "R8 base config");
      sample(2600, 1'b1, 8'hE0, "R8 pole+code change with sample");
      sample(2600, 1'b0, 8'h20, "R8 pole back with new code");
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_two_pole();
      t_four_pole();
      t_offset();
      t_fold();
      t_table();
      t_hold();
      t_same_cycle();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule